// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block erases a region of a serial NOR flash device. A client supplies a start address, a byte length, the device capacity and a table of up to four erase granules. Each granule is a size exponent paired with an opcode. The sequencer checks the request against the device bounds and the 4 KB erase granularity. It then drives a single-outstanding transaction-request port that some serial controller turns into wire traffic.

A request that covers the whole device is served by one chip-erase command. Otherwise the region is consumed step by step. At each step the largest table granule that divides both the current address and the bytes still to erase is used. Every erase is preceded by a write-enable and followed by status polling until the flash reports idle. The run always closes with a write-disable. A single-cycle `done` pulse reports completion, with `err` qualifying it.

Top module: `nor_erase_seq`

## Requirements
- R1: A request with `start_addr >= flash_size` or `flash_size - start_addr < erase_len` completes with `done` and `err`=1 and issues no transaction.
- R2: A request inside the device with `erase_len`=0 completes with `err`=0 and issues no transaction, whatever the alignment of its address.
- R3: A valid, nonzero request whose address or length has any of bits [11:0] set completes with `err`=1 and issues no transaction. Every addressed erase carries an address with bits [11:0] clear.
- R4: When `erase_len` equals `flash_size`, the sequence is write-enable (0x06), then chip erase (0xC7) with `req_addr_en`=0 and `req_addr`=0, then the status polls, then write-disable (0x04). `err` is 0.
- R5: Table entry i takes exponent bits [i*EW +: EW] of `type_exp` and opcode bits [i*8 +: 8] of `type_op`. At each step the chosen entry is the one with the largest nonzero exponent e for which 2^e divides both the current address and the remaining length. On a tie the lower index wins. An exponent of 0 marks an unused entry.
- R6: The chosen opcode is issued with `req_addr_en`=1 and the current address. The address then advances and the remaining length shrinks by 2^e, until the remaining length is zero.
- R7: When no entry qualifies, no further erase is issued, write-disable (0x04) is sent and the run ends with `err`=1.
- R8: After each erase, status reads (opcode 0x05, `req_read`=1) repeat until the returned byte ANDed with `WIP_MASK` (default 0x01) is zero. Only then is the next command issued.
- R9: Every erase command is immediately preceded by an accepted write-enable (0x06). Every run that issues any command ends with write-disable (0x04).
- R10: While `req_valid`=1 and `req_ready`=0, `req_valid`, `req_op` and `req_addr` hold. `req_valid` is 0 while the block is idle and while it waits for `rsp_valid`.
- R11: `done` is a one-cycle pulse. `err` is high only together with `done`. After reset `busy`, `done` and `req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request (sampled when idle) |
| start_addr | input | AW | First byte to erase |
| erase_len | input | AW+1 | Bytes to erase |
| flash_size | input | AW+1 | Device capacity in bytes |
| type_exp | input | NTYPE*EW | Packed granule size exponents |
| type_op | input | NTYPE*8 | Packed granule opcodes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Request rejected or stopped, valid with done |
| req_valid | output | 1 | Transaction request valid |
| req_ready | input | 1 | Transaction request accepted |
| req_op | output | 8 | Command opcode |
| req_addr | output | AW | Command address |
| req_addr_en | output | 1 | Command carries an address |
| req_read | output | 1 | Command reads one status byte |
| rsp_valid | input | 1 | Transaction completed |
| rsp_data | input | 8 | Status byte returned by a read |

## Verification
The address advance and the next granule choice meet in the same cycle. The remaining length drops at the erase completion, and the next pick must then see both the new address and the new length together. A stale address or a stale length gives a different choice only at particular offsets. The bench therefore sweeps every 4 KB-aligned start and length across a 64 KB device with two granule tables. It compares each accepted command, opcode and address, against a list rebuilt arithmetically from the rules. Ready stalls and varying busy-poll counts are mixed in, so that acceptance and completion land on different cycles relative to the choice.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_CHIP  = 8'hC7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PICK,
        ST_REQ,
        ST_RSP,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_WREN,
        PH_ERASE,
        PH_POLL,
        PH_WRDI
    } seq_phase_e;

endpackage

// File: rtl/nor_erase_check.sv
module nor_erase_check #(
    parameter int AW       = 24,
    parameter int SECT_LOG = 12
) (
    input  logic [AW-1:0] addr,
    input  logic [AW:0]   len,
    input  logic [AW:0]   fsize,
    output logic          out_of_range,
    output logic          zero_len,
    output logic          misaligned,
    output logic          whole
);
    logic [AW:0] addr_w;
    logic [AW:0] room;

    always_comb begin
        addr_w       = {1'b0, addr};
        room         = fsize - addr_w;
        out_of_range = (addr_w >= fsize) || (room < len);
        zero_len     = (len == '0);
        misaligned   = (|addr[SECT_LOG-1:0]) || (|len[SECT_LOG-1:0]);
        whole        = (len == fsize);
    end

endmodule

// File: rtl/nor_erase_pick.sv
module nor_erase_pick #(
    parameter int AW    = 24,
    parameter int NTYPE = 4,
    parameter int EW    = 5,
    localparam int IW   = (NTYPE > 1) ? $clog2(NTYPE) : 1,
    localparam int MW   = AW + 1
) (
    input  logic [AW-1:0]       cur_addr,
    input  logic [AW:0]         remain,
    input  logic [NTYPE*EW-1:0] exps,
    output logic                hit,
    output logic [IW-1:0]       idx
);
    logic [NTYPE-1:0] fit;
    logic [MW-1:0]    both;

    assign both = {1'b0, cur_addr} | remain;

    for (genvar g = 0; g < NTYPE; g++) begin : g_fit
        logic [EW-1:0] e;
        logic [MW-1:0] msk;
        assign e = exps[g*EW +: EW];
        always_comb begin
            if (32'(e) >= MW) msk = '1;
            else              msk = (MW'(1) << e) - MW'(1);
            fit[g] = (e != '0) && ((both & msk) == '0);
        end
    end

    always_comb begin
        logic [EW-1:0] best;
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NTYPE; i++) begin
            if (fit[i] && (!hit || exps[i*EW +: EW] > best)) begin
                hit  = 1'b1;
                idx  = IW'(i);
                best = exps[i*EW +: EW];
            end
        end
    end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int          AW       = 24,
    parameter int          NTYPE    = 4,
    parameter int          EW       = 5,
    parameter int          SECT_LOG = 12,
    parameter logic [7:0]  WIP_MASK = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [AW-1:0]       start_addr,
    input  logic [AW:0]         erase_len,
    input  logic [AW:0]         flash_size,
    input  logic [NTYPE*EW-1:0] type_exp,
    input  logic [NTYPE*8-1:0]  type_op,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [7:0]          req_op,
    output logic [AW-1:0]       req_addr,
    output logic                req_addr_en,
    output logic                req_read,
    input  logic                rsp_valid,
    input  logic [7:0]          rsp_data
);
    localparam int IW = (NTYPE > 1) ? $clog2(NTYPE) : 1;

    typedef struct packed {
        seq_state_e          st;
        seq_phase_e          ph;
        logic [AW-1:0]       addr;
        logic [AW:0]         remain;
        logic [AW:0]         fsize;
        logic [NTYPE*EW-1:0] exps;
        logic [NTYPE*8-1:0]  ops;
        logic                chip;
        logic [7:0]          op;
        logic [EW-1:0]       exp;
        logic                err;
        logic [7:0]          last_op;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          bad_range, len_zero, bad_align, is_whole;
    logic          pick_hit;
    logic [IW-1:0] pick_idx;
    logic [AW:0]   step;
    logic [7:0]    cur_op;

    nor_erase_check #(.AW(AW), .SECT_LOG(SECT_LOG)) u_check (
        .addr         (ctl_q.addr),
        .len          (ctl_q.remain),
        .fsize        (ctl_q.fsize),
        .out_of_range (bad_range),
        .zero_len     (len_zero),
        .misaligned   (bad_align),
        .whole        (is_whole)
    );

    nor_erase_pick #(.AW(AW), .NTYPE(NTYPE), .EW(EW)) u_pick (
        .cur_addr (ctl_q.addr),
        .remain   (ctl_q.remain),
        .exps     (ctl_q.exps),
        .hit      (pick_hit),
        .idx      (pick_idx)
    );

    assign step = (AW+1)'(1) << ctl_q.exp;

    always_comb begin
        unique case (ctl_q.ph)
            PH_WREN:  cur_op = OP_WREN;
            PH_ERASE: cur_op = ctl_q.op;
            PH_POLL:  cur_op = OP_RDSR;
            default:  cur_op = OP_WRDI;
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.addr   = start_addr;
                    ctl_d.remain = erase_len;
                    ctl_d.fsize  = flash_size;
                    ctl_d.exps   = type_exp;
                    ctl_d.ops    = type_op;
                    ctl_d.err    = 1'b0;
                    ctl_d.chip   = 1'b0;
                    ctl_d.st     = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (bad_range) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_DONE;
                end else if (len_zero) begin
                    ctl_d.st  = ST_DONE;
                end else if (bad_align) begin
                    ctl_d.err = 1'b1;
                    ctl_d.st  = ST_DONE;
                end else if (is_whole) begin
                    ctl_d.chip = 1'b1;
                    ctl_d.op   = OP_CHIP;
                    ctl_d.ph   = PH_WREN;
                    ctl_d.st   = ST_REQ;
                end else begin
                    ctl_d.st   = ST_PICK;
                end
            end
            ST_PICK: begin
                if (pick_hit) begin
                    ctl_d.op  = ctl_q.ops[pick_idx*8 +: 8];
                    ctl_d.exp = ctl_q.exps[pick_idx*EW +: EW];
                    ctl_d.ph  = PH_WREN;
                end else begin
                    ctl_d.err = 1'b1;
                    ctl_d.ph  = PH_WRDI;
                end
                ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (req_ready) begin
                    ctl_d.last_op = cur_op;
                    ctl_d.st      = ST_RSP;
                end
            end
            ST_RSP: begin
                if (rsp_valid) begin
                    ctl_d.st = ST_REQ;
                    unique case (ctl_q.ph)
                        PH_WREN:  ctl_d.ph = PH_ERASE;
                        PH_ERASE: begin
                            if (ctl_q.chip) begin
                                ctl_d.remain = '0;
                            end else begin
                                ctl_d.addr   = ctl_q.addr + step[AW-1:0];
                                ctl_d.remain = ctl_q.remain - step;
                            end
                            ctl_d.ph = PH_POLL;
                        end
                        PH_POLL: begin
                            if ((rsp_data & WIP_MASK) != '0) ctl_d.ph = PH_POLL;
                            else if (ctl_q.remain == '0)      ctl_d.ph = PH_WRDI;
                            else                              ctl_d.st = ST_PICK;
                        end
                        default:  ctl_d.st = ST_DONE;
                    endcase
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_IDLE;
            ctl_q.ph      <= PH_WREN;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = (ctl_q.st == ST_DONE);
    assign err         = done && ctl_q.err;
    assign req_valid   = (ctl_q.st == ST_REQ);
    assign req_op      = cur_op;
    assign req_addr_en = (ctl_q.ph == PH_ERASE) && !ctl_q.chip;
    assign req_addr    = req_addr_en ? ctl_q.addr : '0;
    assign req_read    = (ctl_q.ph == PH_POLL);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R11
    AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (ctl_q.ph == PH_ERASE) |-> ctl_q.last_op == OP_WREN); // R9
    AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_addr_en |-> req_addr[SECT_LOG-1:0] == '0); // R3
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R10

endmodule

// File: tb/nor_erase_seq_test.sv
module nor_erase_seq_test;
    localparam int AW = 17;
    localparam int NT = 4;
    localparam int EW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW:0] erase_len = '0;
    logic [AW:0] flash_size = '0;
    logic [NT*EW-1:0] type_exp = '0;
    logic [NT*8-1:0] type_op = '0;
    logic busy, done, err, req_valid, req_addr_en, req_read;
    logic req_ready = 1'b0;
    logic rsp_valid = 1'b0;
    logic [7:0] rsp_data = '0;
    logic [7:0] req_op;
    logic [AW-1:0] req_addr;

    always #2 clk = ~clk;

    nor_erase_seq #(.AW(AW), .NTYPE(NT), .EW(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .erase_len(erase_len), .flash_size(flash_size), .type_exp(type_exp),
        .type_op(type_op), .busy(busy), .done(done), .err(err),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_addr_en(req_addr_en), .req_read(req_read),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int got_op[256], got_ad[256], got_ae[256], got_rd[256];
    int n_got = 0;
    int exp_op[256], exp_ad[256], exp_ae[256], exp_rd[256];
    int n_exp = 0;
    int exp_err = 0;
    int tb_e[NT], tb_o[NT];
    int busy_polls = 0;
    int busy_left = 0;

    task automatic fail(input string tag, input string what, input int act, input int expv);
        n_bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    endtask

    task automatic chk(input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) fail(tag, what, act, expv);
    endtask

    // flash and transport model
    initial begin : model
        int tog = 0;
        bit pend = 0;
        int pdata = 0;
        bit hold = 0;
        int h_op = 0, h_ad = 0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_data  = 8'(pdata);
                pend = 0;
            end
            if (hold) begin
                n_chk++;
                if (!req_valid || int'(req_op) != h_op || int'(req_addr) != h_ad)
                    fail("R10", "request held", int'(req_op), h_op);
            end
            tog++;
            req_ready = (tog % 3) != 0;
            hold = req_valid && !req_ready;
            h_op = int'(req_op);
            h_ad = int'(req_addr);
            if (req_valid && req_ready) begin
                if (n_got < 256) begin
                    got_op[n_got] = int'(req_op);
                    got_ad[n_got] = int'(req_addr);
                    got_ae[n_got] = int'(req_addr_en);
                    got_rd[n_got] = int'(req_read);
                end
                n_got++;
                pdata = 0;
                if (req_op == 8'h05) begin
                    pdata = (busy_left != 0) ? 8'hA3 : 8'hA2;
                    if (busy_left > 0) busy_left--;
                end else if (req_op != 8'h06 && req_op != 8'h04) begin
                    busy_left = busy_polls;
                end
                pend = 1;
            end
        end
    end

    function automatic void push(input int op, input int ad, input int ae, input int rd);
        exp_op[n_exp] = op; exp_ad[n_exp] = ad; exp_ae[n_exp] = ae; exp_rd[n_exp] = rd;
        n_exp++;
    endfunction

    function automatic void build(input int a, input int l, input int f);
        n_exp = 0;
        exp_err = 0;
        if (a >= f || f - a < l) begin exp_err = 1; return; end
        if (l == 0) return;
        if ((a % 4096) != 0 || (l % 4096) != 0) begin exp_err = 1; return; end
        if (l == f) begin
            push(8'h06, 0, 0, 0);
            push(8'hC7, 0, 0, 0);
            for (int p = 0; p <= busy_polls; p++) push(8'h05, 0, 0, 1);
            push(8'h04, 0, 0, 0);
            return;
        end
        while (l > 0) begin
            int best = -1;
            for (int k = 0; k < NT; k++) begin
                int sz = 1 << tb_e[k];
                if (tb_e[k] != 0 && tb_e[k] <= AW && (a % sz) == 0 && (l % sz) == 0 &&
                    (best < 0 || tb_e[k] > tb_e[best])) best = k;
            end
            if (best < 0) begin exp_err = 1; break; end
            push(8'h06, 0, 0, 0);
            push(tb_o[best], a, 1, 0);
            for (int p = 0; p <= busy_polls; p++) push(8'h05, 0, 0, 1);
            a += 1 << tb_e[best];
            l -= 1 << tb_e[best];
        end
        push(8'h04, 0, 0, 0);
    endfunction

    task automatic set_table(input int e0, o0, e1, o1, e2, o2, e3, o3);
        tb_e[0] = e0; tb_o[0] = o0; tb_e[1] = e1; tb_o[1] = o1;
        tb_e[2] = e2; tb_o[2] = o2; tb_e[3] = e3; tb_o[3] = o3;
        for (int k = 0; k < NT; k++) begin
            type_exp[k*EW +: EW] = EW'(tb_e[k]);
            type_op[k*8 +: 8]    = 8'(tb_o[k]);
        end
    endtask

    task automatic run_case(input int a, input int l, input int f, input int bp, input string tag);
        int w = 0;
        int e_got;
        busy_polls = bp;
        build(a, l, f);
        @(negedge clk);
        n_got = 0;
        start_addr = AW'(a);
        erase_len  = (AW+1)'(l);
        flash_size = (AW+1)'(f);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 6000) begin @(negedge clk); w++; end
        if (!done) begin
            n_chk++;
            fail(tag, "no done", 0, 1);
            return;
        end
        e_got = int'(err);
        @(negedge clk);
        chk("R11", "done one cycle", int'(done), 0);
        chk(exp_err ? ((n_exp == 0) ? tag : "R7") : tag, "err flag", e_got, exp_err);
        chk("R6", "command count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            string t;
            if (exp_op[i] == 8'h05) t = "R8";
            else if (exp_op[i] == 8'h06 || exp_op[i] == 8'h04) t = "R9";
            else if (exp_op[i] == 8'hC7) t = "R4";
            else t = "R5";
            chk(t, "opcode", got_op[i], exp_op[i]);
            chk(t, "addr", got_ad[i], exp_ad[i]);
            chk(t, "addr_en/read", got_ae[i]*2 + got_rd[i], exp_ae[i]*2 + exp_rd[i]);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "busy after reset", int'(busy), 0);
        chk("R11", "done after reset", int'(done), 0);
        chk("R10", "req_valid after reset", int'(req_valid), 0);

        // R1 bounds
        set_table(12, 8'h20, 15, 8'h52, 16, 8'hD8, 0, 8'h00);
        run_case(65536, 0, 65536, 0, "R1");
        run_case(61440, 8192, 65536, 1, "R1");
        run_case(0, 131072, 65536, 0, "R1");
        // R2 zero length, unaligned address allowed
        run_case(16, 0, 65536, 0, "R2");
        run_case(4096, 0, 65536, 0, "R2");
        // R3 alignment
        run_case(256, 4096, 65536, 0, "R3");
        run_case(0, 2048, 65536, 0, "R3");
        run_case(8192, 4097, 65536, 0, "R3");
        // R4 whole device
        run_case(0, 65536, 65536, 2, "R4");

        // sweep table 1
        for (int a = 0; a <= 16; a++)
            for (int l = 0; l <= 16; l++) begin
                run_case(a*4096, l*4096, 65536, cnt % 3, "R6");
                cnt++;
            end

        // sweep table 2: unused slot with exp 0, duplicate 64K entries (lower index wins)
        set_table(0, 8'hAA, 16, 8'hD8, 12, 8'h20, 16, 8'hDC);
        for (int a = 0; a <= 16; a++)
            for (int l = 0; l <= 16; l++) begin
                run_case(a*4096, l*4096, 65536, cnt % 3, "R5");
                cnt++;
            end

        // R7: only a 64K granule, on a 128K device; exp-0 slot must stay unused (R5)
        set_table(0, 8'h20, 16, 8'hD8, 0, 8'h52, 0, 8'h00);
        run_case(0, 65536, 131072, 1, "R5");
        run_case(65536, 65536, 131072, 0, "R5");
        run_case(4096, 4096, 131072, 0, "R7");
        run_case(0, 69632, 131072, 1, "R7");
        run_case(0, 131072, 131072, 0, "R4");

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule